// File: doc/BRIEF.md
# Pseudo-static RAM low-power mode controller

This block is the device-side control for a pseudo-static RAM model. It watches the chip-select, write-enable and low-power pins together with the five low address bits. It keeps a five-bit low-power configuration word and tracks which power state the device is in. From the configuration word it derives the window of the array that stays refreshed, or that stays addressable in reduced-size operation.

The configuration word is loaded by an ordinary write cycle. That write must begin shortly after the low-power pin falls. A low-power period with deep power down programmed and no update in it puts the device into deep power down. Leaving deep power down restores every field to its default and holds the device busy for a recovery interval. In reduced-size operation, an access outside the selected window is flagged and is not allowed.

Top module: `psr_lp_ctrl`

## Requirements
- R1: After reset the configuration word reads 5'b10000 and the state is STANDBY. The state codes are ACTIVE=0, STANDBY=1, PARTIAL=2, REDUCED=3, DEEP=4 and RECOVER=5. The window is the full array (base 0, size 2^ADDR_W), and busy is low.
- R2: A write starts on the first cycle with sel_ni and wr_ni both low. A write that starts while lp_ni is low, within the first CLK_PER_US*UPD_WIN_US cycles of the low period, loads the configuration word from mode_addr_i. Bit 4 is the deep-power-down disable (0 arms it). Bit 3 selects the array mode (0 partial refresh, 1 reduced size). Bit 2 selects the top half (1) or the bottom half (0). Bits 1..0 give the area (00 full, 10 half, 11 quarter).
- R3: A write that starts after that window has closed, or while lp_ni is high, leaves the configuration word unchanged.
- R4: A load with area code 01 keeps the previous area field and still updates bits 4..2.
- R5: The window size is 2^ADDR_W for a full area, 2^(ADDR_W-1) for a half and 2^(ADDR_W-2) for a quarter. The base is 0 when bit 2 is 0, and 2^ADDR_W minus the size when bit 2 is 1.
- R6: While lp_ni is high and no recovery is running, the state is REDUCED if bit 3 is 1. Otherwise it is ACTIVE when sel_ni was low and STANDBY when sel_ni was high. A low lp_ni moves a running device to PARTIAL on the next edge.
- R7: In REDUCED, with sel_ni low, an address inside the window raises access_ok_o and an address outside it raises oor_o. The two flags are never high together.
- R8: A low-power state lasts at least CLK_PER_US*LP_MIN_US cycles. An earlier rise of lp_ni is held off until that time has passed.
- R9: If bit 4 is 0 and the current low period carried no update, the state moves from PARTIAL to DEEP once the update window closes. A low period that carries an update stays PARTIAL.
- R10: Leaving DEEP enters RECOVER and resets the configuration word to 5'b10000. RECOVER lasts CLK_PER_US*REC_US cycles whatever lp_ni does. No access is allowed during it.
- R11: busy_o is high exactly in PARTIAL, DEEP and RECOVER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write enable, active low |
| lp_ni | input | 1 | Low-power request, active low |
| mode_addr_i | input | 5 | Address bits 4..0, the configuration source |
| acc_addr_i | input | ADDR_W | Full access address for the window check |
| pstate_o | output | 3 | Power state code |
| mode_o | output | 5 | Current configuration word |
| region_base_o | output | ADDR_W | First word of the selected window |
| region_size_o | output | ADDR_W+1 | Number of words in the window |
| access_ok_o | output | 1 | Access permitted this cycle |
| oor_o | output | 1 | Access falls outside the reduced window |
| busy_o | output | 1 | Low-power or recovery state |

## Verification
The bench builds the block with ADDR_W=8 and CLK_PER_US=4, and keeps the default microsecond counts. Window bases and sizes are then small values that are easy to read, such as 128 and 192. The update window is four cycles, so an accepted write and a rejected write can sit on adjacent edges. The 40-cycle minimum low time and the 800-cycle recovery fit many times into one run, so deep-power-down entry, exit and the full recovery can each be checked from end to end.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [2:0] {
    PS_ACTIVE  = 3'd0,
    PS_STANDBY = 3'd1,
    PS_PARTIAL = 3'd2,
    PS_REDUCED = 3'd3,
    PS_DEEP    = 3'd4,
    PS_RECOVER = 3'd5
  } psr_state_e;

  // bit layout follows the address bits it is loaded from
  typedef struct packed {
    logic       dpd_n;
    logic       rms;
    logic       top;
    logic [1:0] area;
  } psr_mode_t;

  localparam psr_mode_t MODE_DEFAULT = '{dpd_n: 1'b1, rms: 1'b0, top: 1'b0, area: 2'b00};
  localparam logic [1:0] AREA_FULL = 2'b00;
  localparam logic [1:0] AREA_RSVD = 2'b01;
  localparam logic [1:0] AREA_HALF = 2'b10;
  localparam logic [1:0] AREA_QUAR = 2'b11;

endpackage

// File: rtl/psr_mode_reg.sv
module psr_mode_reg
  import psr_pkg::*;
#(
  parameter int unsigned WIN_CYC = 100
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sel_ni,
  input  logic      wr_ni,
  input  logic      lp_ni,
  input  logic [4:0] addr_i,
  input  logic      clear_i,
  output psr_mode_t mode_o,
  output logic      win_open_o,
  output logic      upd_seen_o
);

  localparam int unsigned CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0] WIN_END = CNT_W'(WIN_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             wr_act_q, upd_seen_q, wr_start, upd;
  psr_mode_t        mode_q, mode_d;

  assign wr_start   = ~sel_ni & ~wr_ni & ~wr_act_q;
  assign win_open_o = ~lp_ni & (cnt_q < WIN_END);
  assign upd        = wr_start & win_open_o;

  always_comb begin
    mode_d = mode_q;
    if (clear_i) begin
      mode_d = MODE_DEFAULT;
    end else if (upd) begin
      mode_d.dpd_n = addr_i[4];
      mode_d.rms   = addr_i[3];
      mode_d.top   = addr_i[2];
      if (addr_i[1:0] != AREA_RSVD) mode_d.area = addr_i[1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      wr_act_q   <= 1'b0;
      upd_seen_q <= 1'b0;
      mode_q     <= MODE_DEFAULT;
    end else begin
      wr_act_q <= ~sel_ni & ~wr_ni;
      mode_q   <= mode_d;
      if (lp_ni) begin
        cnt_q      <= '0;
        upd_seen_q <= 1'b0;
      end else begin
        if (cnt_q < WIN_END) cnt_q <= cnt_q + 1'b1;
        if (upd) upd_seen_q <= 1'b1;
      end
    end
  end

  assign mode_o     = mode_q;
  assign upd_seen_o = upd_seen_q;

  assert_no_write_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_ni && !clear_i) |=> $stable(mode_q));

  assert_reserved_area_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && addr_i[1:0] == AREA_RSVD && !clear_i) |=> mode_q.area == $past(mode_q.area));

endmodule

// File: rtl/psr_region_dec.sv
module psr_region_dec
  import psr_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  psr_mode_t         mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W:0]   size_o,
  output logic              in_range_o
);

  localparam logic [ADDR_W:0] FULL_SZ = {1'b1, {ADDR_W{1'b0}}};

  logic [ADDR_W:0] top_base, offset;

  always_comb begin
    unique case (mode_i.area)
      AREA_HALF: size_o = FULL_SZ >> 1;
      AREA_QUAR: size_o = FULL_SZ >> 2;
      default:   size_o = FULL_SZ;
    endcase
  end

  assign top_base   = FULL_SZ - size_o;
  assign base_o     = mode_i.top ? top_base[ADDR_W-1:0] : '0;
  assign offset     = {1'b0, addr_i} - {1'b0, base_o};
  assign in_range_o = (addr_i >= base_o) && (offset < size_o);

endmodule

// File: rtl/psr_power_fsm.sv
module psr_power_fsm
  import psr_pkg::*;
#(
  parameter int unsigned LP_CYC  = 1000,
  parameter int unsigned REC_CYC = 20000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lp_ni,
  input  logic       sel_ni,
  input  logic       rms_i,
  input  logic       dpd_arm_i,
  input  logic       upd_seen_i,
  input  logic       win_open_i,
  output psr_state_e state_o,
  output logic       clear_o
);

  localparam int unsigned TMR_MAX = (LP_CYC > REC_CYC) ? LP_CYC : REC_CYC;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] LP_LAST  = TMR_W'(LP_CYC - 1);
  localparam logic [TMR_W-1:0] REC_LAST = TMR_W'(REC_CYC - 1);

  psr_state_e       st_q, st_d, run_st;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  assign run_st = rms_i ? PS_REDUCED : (!sel_ni ? PS_ACTIVE : PS_STANDBY);

  always_comb begin
    st_d    = st_q;
    tmr_d   = tmr_q;
    clear_o = 1'b0;
    unique case (st_q)
      PS_RECOVER: begin
        if (tmr_q == REC_LAST) st_d = run_st;
        else                   tmr_d = tmr_q + 1'b1;
      end
      PS_PARTIAL, PS_DEEP: begin
        if (tmr_q < LP_LAST) tmr_d = tmr_q + 1'b1;
        if (lp_ni && tmr_q >= LP_LAST) begin
          if (st_q == PS_DEEP) begin
            st_d    = PS_RECOVER;
            tmr_d   = '0;
            clear_o = 1'b1;
          end else begin
            st_d = run_st;
          end
        end else if (!lp_ni && st_q == PS_PARTIAL && dpd_arm_i && !upd_seen_i && !win_open_i) begin
          st_d = PS_DEEP;
        end
      end
      default: begin
        if (!lp_ni) begin
          st_d  = PS_PARTIAL;
          tmr_d = '0;
        end else begin
          st_d = run_st;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PS_STANDBY;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign state_o = st_q;

  assert_low_min_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == PS_PARTIAL || st_q == PS_DEEP) && lp_ni && tmr_q < LP_LAST)
      |=> (st_q == PS_PARTIAL || st_q == PS_DEEP));

  assert_deep_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_DEEP && !lp_ni) |=> st_q == PS_DEEP);

  assert_deep_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_DEEP && lp_ni && tmr_q >= LP_LAST) |=> st_q == PS_RECOVER);

  assert_recover_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_RECOVER && tmr_q != REC_LAST) |=> st_q == PS_RECOVER);

endmodule

// File: rtl/psr_lp_ctrl.sv
module psr_lp_ctrl
  import psr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned CLK_PER_US = 100,
  parameter int unsigned UPD_WIN_US = 1,
  parameter int unsigned LP_MIN_US  = 10,
  parameter int unsigned REC_US     = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              wr_ni,
  input  logic              lp_ni,
  input  logic [4:0]        mode_addr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic [2:0]        pstate_o,
  output logic [4:0]        mode_o,
  output logic [ADDR_W-1:0] region_base_o,
  output logic [ADDR_W:0]   region_size_o,
  output logic              access_ok_o,
  output logic              oor_o,
  output logic              busy_o
);

  localparam int unsigned WIN_CYC = CLK_PER_US * UPD_WIN_US;
  localparam int unsigned LP_CYC  = CLK_PER_US * LP_MIN_US;
  localparam int unsigned REC_CYC = CLK_PER_US * REC_US;

  psr_mode_t  mode;
  psr_state_e state;
  logic       win_open, upd_seen, clear, in_range, running;

  psr_mode_reg #(.WIN_CYC(WIN_CYC)) i_mode_reg (
    .clk_i, .rst_ni, .sel_ni, .wr_ni, .lp_ni,
    .addr_i     (mode_addr_i),
    .clear_i    (clear),
    .mode_o     (mode),
    .win_open_o (win_open),
    .upd_seen_o (upd_seen)
  );

  psr_power_fsm #(.LP_CYC(LP_CYC), .REC_CYC(REC_CYC)) i_power_fsm (
    .clk_i, .rst_ni, .lp_ni, .sel_ni,
    .rms_i      (mode.rms),
    .dpd_arm_i  (~mode.dpd_n),
    .upd_seen_i (upd_seen),
    .win_open_i (win_open),
    .state_o    (state),
    .clear_o    (clear)
  );

  psr_region_dec #(.ADDR_W(ADDR_W)) i_region_dec (
    .mode_i     (mode),
    .addr_i     (acc_addr_i),
    .base_o     (region_base_o),
    .size_o     (region_size_o),
    .in_range_o (in_range)
  );

  assign running     = (state == PS_ACTIVE) || (state == PS_STANDBY) || (state == PS_REDUCED);
  assign access_ok_o = ~sel_ni & running & ((state != PS_REDUCED) | in_range);
  assign oor_o       = ~sel_ni & (state == PS_REDUCED) & ~in_range;
  assign busy_o      = ~running;
  assign pstate_o    = state;
  assign mode_o      = mode;

  assert_flags_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({access_ok_o, oor_o}));

  assert_busy_no_access_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !access_ok_o);

endmodule

// File: tb/test_psr_lp_ctrl.sv
module test_psr_lp_ctrl;

  localparam int AW    = 8;
  localparam int CPU   = 4;
  localparam int LPMIN = CPU * 10;
  localparam int REC   = CPU * 200;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sel_ni = 1'b1, wr_ni = 1'b1, lp_ni = 1'b1;
  logic [4:0]    mode_addr = '0;
  logic [AW-1:0] acc_addr = '0;
  logic [2:0]    pstate;
  logic [4:0]    mode;
  logic [AW-1:0] base;
  logic [AW:0]   size;
  logic          access_ok, oor, busy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  psr_lp_ctrl #(.ADDR_W(AW), .CLK_PER_US(CPU)) i_psr_lp_ctrl (
    .clk_i(clk), .rst_ni, .sel_ni, .wr_ni, .lp_ni,
    .mode_addr_i(mode_addr), .acc_addr_i(acc_addr),
    .pstate_o(pstate), .mode_o(mode), .region_base_o(base), .region_size_o(size),
    .access_ok_o(access_ok), .oor_o(oor), .busy_o(busy)
  );

  typedef struct packed {
    logic [4:0] bits;
    logic [4:0] exp_mode;
    logic [7:0] exp_base;
    logic [8:0] exp_size;
    logic [2:0] exp_state;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{5'b11010, 5'b11010, 8'd0,   9'd128, 3'd3},
    '{5'b11111, 5'b11111, 8'd192, 9'd64,  3'd3},
    '{5'b11101, 5'b11111, 8'd192, 9'd64,  3'd3},
    '{5'b10110, 5'b10110, 8'd128, 9'd128, 3'd1},
    '{5'b10000, 5'b10000, 8'd0,   9'd256, 3'd1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // low period: optional write starting wr_at cycles after lp falls, then exit
  task automatic low_period(input logic [4:0] bits, input bit do_wr, input int wr_at);
    lp_ni = 1'b0;
    tick(wr_at);
    if (do_wr) begin
      mode_addr = bits; sel_ni = 1'b0; wr_ni = 1'b0;
      tick(1);
      sel_ni = 1'b1; wr_ni = 1'b1;
    end
    tick(LPMIN + 4);
    lp_ni = 1'b1;
    tick(2);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    // R1 reset state
    check("R1 state", pstate, 1);
    check("R1 mode", mode, 5'b10000);
    check("R1 base", base, 0);
    check("R1 size", size, 256);
    check("R1 busy", busy, 0);
    rst_ni = 1'b1;
    tick(2);

    // R6 active when selected
    sel_ni = 1'b0;
    tick(2);
    check("R6 active", pstate, 0);
    check("R6 access", access_ok, 1);
    sel_ni = 1'b1;
    tick(2);
    check("R6 standby", pstate, 1);

    // R2 R4 R5 table walk
    foreach (VECS[i]) begin
      low_period(VECS[i].bits, 1'b1, 1);
      check($sformatf("R2/R4 mode v%0d", i), mode, VECS[i].exp_mode);
      check($sformatf("R5 base v%0d", i), base, VECS[i].exp_base);
      check($sformatf("R5 size v%0d", i), size, VECS[i].exp_size);
      check($sformatf("R6 state v%0d", i), pstate, VECS[i].exp_state);
    end

    // R7 reduced-size range check: top half 128..255
    low_period(5'b11110, 1'b1, 1);
    check("R6 reduced", pstate, 3);
    sel_ni = 1'b0; acc_addr = 8'h10;
    tick(1);
    check("R7 oor low addr", oor, 1);
    check("R7 no access low addr", access_ok, 0);
    acc_addr = 8'h90;
    tick(1);
    check("R7 access in window", access_ok, 1);
    check("R7 no oor in window", oor, 0);
    sel_ni = 1'b1;

    // R3 late write rejected, last accepted slot
    low_period(5'b10011, 1'b1, 4);
    check("R3 late write ignored", mode, 5'b11110);
    low_period(5'b10011, 1'b1, 3);
    check("R2 last window slot", mode, 5'b10011);
    check("R6 back to standby", pstate, 1);

    // R3 write with lp high ignored
    mode_addr = 5'b11111; sel_ni = 1'b0; wr_ni = 1'b0;
    tick(1);
    sel_ni = 1'b1; wr_ni = 1'b1;
    tick(1);
    check("R3 write while high ignored", mode, 5'b10011);

    // R8 minimum low time, R11 busy
    lp_ni = 1'b0;
    tick(3);
    check("R6 partial entry", pstate, 2);
    check("R11 busy partial", busy, 1);
    lp_ni = 1'b1;
    tick(2);
    check("R8 early exit held", pstate, 2);
    tick(LPMIN);
    check("R8 exit after min", pstate, 1);

    // R9 arm deep power down
    low_period(5'b00000, 1'b1, 1);
    check("R2 armed mode", mode, 5'b00000);
    // period carrying an update stays partial
    lp_ni = 1'b0;
    tick(1);
    mode_addr = 5'b00000; sel_ni = 1'b0; wr_ni = 1'b0;
    tick(1);
    sel_ni = 1'b1; wr_ni = 1'b1;
    tick(8);
    check("R9 update keeps partial", pstate, 2);
    tick(LPMIN);
    lp_ni = 1'b1;
    tick(2);
    // period without update enters deep
    lp_ni = 1'b0;
    tick(3);
    check("R9 not deep inside window", pstate, 2);
    tick(5);
    check("R9 deep entry", pstate, 4);
    check("R11 busy deep", busy, 1);
    tick(LPMIN);
    lp_ni = 1'b1;
    tick(1);
    check("R10 recover", pstate, 5);
    check("R10 defaults restored", mode, 5'b10000);
    sel_ni = 1'b0;
    tick(1);
    check("R10 no access in recovery", access_ok, 0);
    sel_ni = 1'b1;
    lp_ni = 1'b0;
    tick(4);
    lp_ni = 1'b1;
    tick(REC - 10);
    check("R10 still recovering", pstate, 5);
    check("R11 busy recover", busy, 1);
    tick(12);
    check("R10 recovery done", pstate, 1);
    check("R11 busy clear", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule